// File: doc/BRIEF.md
# Voltage-Code Slew Stepper with Power-Good Blanking

This block sits between the target-selection inputs of a core-voltage regulator and its DAC. Whenever the requested code changes, the block does not jump to the new value. It walks the DAC code toward the new value one LSB per slew tick, so the output filter sees a controlled ramp. The slew tick is an enable input that comes from a separate programmable timebase.

The requested code comes from one of two places. When the suspend input is low, the target is the five-bit main code. When the suspend input is high, the target is one of four fixed suspend codes, picked by a two-bit select.

Downward ramps start two ticks late. This models the extra synchronisation delay seen on falling transitions. A ramp-active flag tells downstream fault logic to ignore undervoltage while the code is moving. The power-good output is forced low during a ramp and for a fixed number of ticks after the ramp ends.

Top module: `vcode_slew_stepper`

## Requirements
- R1: The DAC code changes only on a cycle where the slew tick is high and a ramp is active. Each change is exactly one LSB toward the target.
- R2: With the suspend input high, the target is the suspend code picked by the select: 0 gives 3, 1 gives 8, 2 gives 12 and 3 gives 20. With the suspend input low, the target is the main code.
- R3: A rising change of N codes finishes on the N-th tick after the change is registered. Ramp-active is high from the cycle after the change until that final tick.
- R4: A falling change of N codes takes N+2 ticks. The first two ticks after the change leave the code unchanged.
- R5: Power-good equals the external good input, except in two cases where it is low. The first case is while ramp-active is high. The second is for the 24 ticks that follow the final step of a ramp.
- R6: A new target that arrives mid-ramp replaces the old one. Stepping continues from the present code and the direction is chosen again. A falling retarget takes the two-tick delay again. The full blanking window follows the new completion.
- R7: In the cycles after reset, the code equals the selected target with no ramp. Ramp-active is low and power-good follows the good input.
- R8: If the target changes to a value equal to the present code while no ramp is active, no ramp starts and power-good is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slew_tick | input | 1 | One-cycle enable from the slew timebase |
| main_code | input | 5 | Main target code |
| susp_en | input | 1 | Selects the suspend code table as the target source |
| susp_sel | input | 2 | Suspend table index |
| out_ok | input | 1 | Raw output-in-regulation indication |
| dac_code | output | 5 | Code driven to the DAC |
| ramp_active | output | 1 | High while the code is moving toward a target |
| vrok | output | 1 | Blanked power-good |

## Verification
Directed ramps of both directions run against both target sources. Comparing a rising step with a falling step separates correct behaviour from a missing or misplaced two-tick falling delay. A window where the target has changed but no ticks arrive shows whether the code can move without a tick. Retargets mid-ramp show three things: whether stepping resumes from the present code, whether the direction is chosen again, and whether blanking restarts. An equal-code target change shows whether a spurious ramp or blanking window starts. Constrained random targets from a fixed seed then mix step sizes and sources, and every ramp is timed against the tick-count formula and the 24-tick blanking length.

// File: rtl/vcs_pkg.sv
// Package: shared types for the voltage-code slew stepper.
// Assumes: nothing beyond IEEE 1800-2017.
package vcs_pkg;

    // Direction of the ramp in progress
    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

endpackage

// File: rtl/vcs_target_sel.sv
// Module: vcs_target_sel
// Chooses the requested DAC code. With susp_en low the target is the main
// code. With susp_en high the target is an entry of a fixed suspend table,
// indexed by the select. The table is a packed parameter, and entry 0 sits
// in the least significant bits.
// Assumes: purely combinational; the inputs are synchronous to clk.
module vcs_target_sel #(
    parameter int CODE_W = 5,
    parameter int SEL_W  = 2,
    parameter logic [(2**SEL_W)*CODE_W-1:0] SUSP_TABLE = {5'd20, 5'd12, 5'd8, 5'd3}
) (
    input  logic [CODE_W-1:0] main_code_i,
    input  logic              susp_en_i,
    input  logic [SEL_W-1:0]  susp_sel_i,
    output logic [CODE_W-1:0] target_o
);
    localparam int SUSP_N = 2**SEL_W;

    logic [CODE_W-1:0] susp_codes [SUSP_N];

    // Unpack the suspend table into an indexable array
    for (genvar g = 0; g < SUSP_N; g++) begin : g_unpack
        assign susp_codes[g] = SUSP_TABLE[g*CODE_W +: CODE_W];
    end

    // Source mux between the suspend table and the main code
    always_comb begin
        target_o = susp_en_i ? susp_codes[susp_sel_i] : main_code_i;
    end

endmodule

// File: rtl/vcs_ramp.sv
// Module: vcs_ramp
// Holds the registered target and the DAC code, and steps the code toward
// the target by one LSB on each slew tick. A falling ramp first spends
// FALL_EXTRA ticks without moving. A target change has priority over a tick
// that arrives in the same cycle. In reset the code loads the target directly.
// Assumes: tick_i is a one-cycle enable; target_i may change at any cycle.
module vcs_ramp
    import vcs_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int FALL_EXTRA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] target_i,
    output logic [CODE_W-1:0] code_o,
    output logic              active_o
);
    localparam int HOLD_W = (FALL_EXTRA > 0) ? $clog2(FALL_EXTRA + 1) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(FALL_EXTRA);
    localparam logic [CODE_W-1:0] ONE_LSB   = CODE_W'(1);

    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_step;
    logic [HOLD_W-1:0] hold_q;
    logic              active_q;
    ramp_dir_e         dir_q;
    logic              changed;
    logic              goes_down;

    // Detect a new request and its direction relative to the present code
    always_comb begin
        changed   = (target_i != tgt_q);
        goes_down = (target_i < code_q);
        code_step = (dir_q == RAMP_UP) ? code_q + ONE_LSB : code_q - ONE_LSB;
    end

    // Target latch, sync delay, and one-LSB stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q    <= target_i;
            code_q   <= target_i;
            active_q <= 1'b0;
            hold_q   <= '0;
            dir_q    <= RAMP_UP;
        end else if (changed) begin
            tgt_q <= target_i;
            if (target_i != code_q) begin
                active_q <= 1'b1;
                dir_q    <= goes_down ? RAMP_DOWN : RAMP_UP;
                hold_q   <= goes_down ? HOLD_LOAD : '0;
            end else begin
                active_q <= 1'b0;
                hold_q   <= '0;
            end
        end else if (active_q && tick_i) begin
            if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end else begin
                code_q <= code_step;
                if (code_step == tgt_q) begin
                    active_q <= 1'b0;
                end
            end
        end
    end

    assign code_o   = code_q;
    assign active_o = active_q;

    // R1
    tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && code_q != $past(code_q)) |-> ($past(tick_i) && $past(active_q)));

    // R1
    one_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && code_q != $past(code_q)) |->
        (code_q == $past(code_q) + ONE_LSB || code_q == $past(code_q) - ONE_LSB));

    // R3
    idle_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (code_q == tgt_q));

    // R4
    hold_falling_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |-> (active_q && dir_q == RAMP_DOWN));

endmodule

// File: rtl/vcs_blank.sv
// Module: vcs_blank
// Counts the power-good blanking window. The counter is held at its full
// value while a ramp is active. Once the ramp ends, it counts down one step
// per slew tick, and blanking_o stays high until it reaches zero.
// Assumes: active_i is the registered ramp-active flag.
module vcs_blank #(
    parameter int BLANK_TICKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic active_i,
    output logic blanking_o
);
    localparam int CNT_W = $clog2(BLANK_TICKS + 1);
    localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_TICKS);

    logic [CNT_W-1:0] cnt_q;

    // Reload during a ramp, count down on ticks once it ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (active_i) begin
            cnt_q <= BLANK_LOAD;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blanking_o = active_i || (cnt_q != '0);

    // R5
    blank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BLANK_LOAD);

    // R5
    blank_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> (cnt_q == BLANK_LOAD));

    // R5
    blank_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !tick_i && cnt_q != '0) |=> (active_i || $stable(cnt_q)));

endmodule

// File: rtl/vcode_slew_stepper.sv
// Module: vcode_slew_stepper (top)
// Picks the target from the main or suspend source, ramps the DAC code
// toward it on slew ticks, and masks power-good during a ramp and for
// BLANK_TICKS ticks after it.
// Assumes: slew_tick is synchronous to clk and high for single cycles.
module vcode_slew_stepper #(
    parameter int CODE_W      = 5,
    parameter int SEL_W       = 2,
    parameter int BLANK_TICKS = 24,
    parameter int FALL_EXTRA  = 2,
    parameter logic [(2**SEL_W)*CODE_W-1:0] SUSP_TABLE = {5'd20, 5'd12, 5'd8, 5'd3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slew_tick,
    input  logic [CODE_W-1:0] main_code,
    input  logic              susp_en,
    input  logic [SEL_W-1:0]  susp_sel,
    input  logic              out_ok,
    output logic [CODE_W-1:0] dac_code,
    output logic              ramp_active,
    output logic              vrok
);
    logic [CODE_W-1:0] target;
    logic              blanking;

    vcs_target_sel #(
        .CODE_W    (CODE_W),
        .SEL_W     (SEL_W),
        .SUSP_TABLE(SUSP_TABLE)
    ) u_sel (
        .main_code_i(main_code),
        .susp_en_i  (susp_en),
        .susp_sel_i (susp_sel),
        .target_o   (target)
    );

    vcs_ramp #(
        .CODE_W    (CODE_W),
        .FALL_EXTRA(FALL_EXTRA)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (slew_tick),
        .target_i(target),
        .code_o  (dac_code),
        .active_o(ramp_active)
    );

    vcs_blank #(
        .BLANK_TICKS(BLANK_TICKS)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (slew_tick),
        .active_i  (ramp_active),
        .blanking_o(blanking)
    );

    // Power-good gated by the blanking window
    always_comb begin
        vrok = out_ok && !blanking;
    end

    // R5
    vrok_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vrok |-> (!ramp_active && out_ok));

endmodule

// File: tb/vcode_slew_stepper_bench.sv
// Bench for vcode_slew_stepper. It runs directed ramps and then random
// targets from a fixed seed. Expected codes and tick counts come from the
// requirements.
module vcode_slew_stepper_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slew_tick = 1'b0;
    logic [4:0] main_code = 5'd17;
    logic       susp_en = 1'b0;
    logic [1:0] susp_sel = 2'd0;
    logic       out_ok = 1'b1;
    logic [4:0] dac_code;
    logic       ramp_active;
    logic       vrok;

    int checks = 0;
    int failures = 0;
    int cur = 0;

    vcode_slew_stepper u_vcode_slew_stepper (
        .clk        (clk),
        .rst_n      (rst_n),
        .slew_tick  (slew_tick),
        .main_code  (main_code),
        .susp_en    (susp_en),
        .susp_sel   (susp_sel),
        .out_ok     (out_ok),
        .dac_code   (dac_code),
        .ramp_active(ramp_active),
        .vrok       (vrok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int susp_val(input int s);
        case (s)
            0: return 3;
            1: return 8;
            2: return 12;
            default: return 20;
        endcase
    endfunction

    function automatic int pick(input bit s, input int sel, input int m);
        return s ? susp_val(sel) : m;
    endfunction

    task automatic pulse_tick();
        @(negedge clk) slew_tick = 1'b1;
        @(negedge clk) slew_tick = 1'b0;
    endtask

    task automatic apply(input bit s, input int sel, input int m);
        @(negedge clk);
        susp_en = s;
        susp_sel = 2'(sel);
        main_code = 5'(m);
        @(negedge clk);
    endtask

    // Request a target, then run stop_after ticks (stop_after < 0: run to completion)
    task automatic ramp(input bit s, input int sel, input int m, input int stop_after, input string tag);
        int t = pick(s, sel, m);
        bit fall = (t < cur);
        int hold = fall ? 2 : 0;
        int expect_n = (fall ? cur - t + 2 : t - cur);
        int n = 0;
        int b = 0;
        bit was_idle = !ramp_active;
        apply(s, sel, m);
        if (t == cur) begin
            // R8: equal code from idle
            chk(ramp_active == 1'b0, "R8", int'(ramp_active), 0);
            chk(vrok == was_idle, "R8", int'(vrok), int'(was_idle));
            chk(int'(dac_code) == cur, "R8", int'(dac_code), cur);
            return;
        end
        chk(ramp_active == 1'b1, "R3", int'(ramp_active), 1);
        chk(vrok == 1'b0, "R5", int'(vrok), 0);
        while (n < 80) begin
            if (stop_after >= 0 && n == stop_after) return;
            pulse_tick();
            n++;
            if (hold > 0) hold--;
            else cur = fall ? cur - 1 : cur + 1;
            chk(int'(dac_code) == cur, (fall && n <= 2) ? "R4" : "R1", int'(dac_code), cur);
            if (cur == t) begin
                chk(ramp_active == 1'b0, tag, int'(ramp_active), 0);
                break;
            end
            chk(ramp_active == 1'b1, tag, int'(ramp_active), 1);
        end
        chk(n == expect_n, tag, n, expect_n);
        if (s) chk(int'(dac_code) == susp_val(sel), "R2", int'(dac_code), susp_val(sel));
        else   chk(int'(dac_code) == m, "R2", int'(dac_code), m);
        chk(vrok == 1'b0, "R5", int'(vrok), 0);
        while (!vrok && b < 60) begin
            pulse_tick();
            b++;
        end
        chk(b == 24, "R5", b, 24);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset loads target directly
        chk(dac_code == 5'd17, "R7", int'(dac_code), 17);
        chk(ramp_active == 1'b0, "R7", int'(ramp_active), 0);
        chk(vrok == 1'b1, "R7", int'(vrok), 1);
        cur = 17;

        // R1: target changed but no ticks, so no movement
        ramp(0, 0, 25, 0, "R3");
        repeat (6) @(negedge clk);
        chk(int'(dac_code) == cur, "R1", int'(dac_code), cur);
        ramp(0, 0, 25, -1, "R3");

        ramp(0, 0, 9, -1, "R4");
        ramp(1, 2, 0, -1, "R3");
        ramp(1, 3, 0, -1, "R3");
        ramp(1, 0, 0, -1, "R4");
        // R8: same code, other source
        ramp(0, 0, 3, -1, "R8");

        // R6: retarget mid-ramp, both directions
        ramp(0, 0, 20, 5, "R6");
        ramp(0, 0, 4, -1, "R6");
        ramp(0, 0, 30, 3, "R6");
        ramp(0, 0, 10, -1, "R6");
        ramp(0, 0, 0, 1, "R6");
        ramp(0, 0, 15, -1, "R6");

        // R5: power-good follows the good input when not blanked
        @(negedge clk) out_ok = 1'b0;
        @(negedge clk);
        chk(vrok == 1'b0, "R5", int'(vrok), 0);
        out_ok = 1'b1;
        @(negedge clk);
        chk(vrok == 1'b1, "R5", int'(vrok), 1);

        for (int i = 0; i < 24; i++) begin
            bit s = 1'($urandom % 2);
            int sel = int'($urandom % 4);
            int m = int'($urandom % 32);
            int t = pick(s, sel, m);
            ramp(s, sel, m, -1, (t < cur) ? "R4" : "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule